// File: doc/BRIEF.md
# System Configuration Register Decoder

This block holds four 16-bit configuration words for a legacy PC-style system controller. A host reaches them over a 16-bit I/O bus with word or byte accesses. From the stored words the block decodes, every cycle and without further delay, the following outputs:

- chip selects and interrupt-line enables for two serial ports;
- an enable and a chip select for a floppy controller;
- read and write routing, internal or external, for the 64 KB memory window at 0xD0000–0xDFFFF;
- a select for an extra RAM mapped into that window.

The serial, floppy and RAM devices sit outside the block. It only produces the select and routing signals they use.

Each configuration word is claimed at its even port and at the odd port directly above it. A word access moves all 16 bits. A byte access carries its data on bit lanes 7:0 and touches only the half chosen by address bit 0. Reads are combinational from the address. A write is captured on the clock edge where the write strobe is high, and the decoded outputs show the new value from the next cycle.

Top module: `sysctl_cfg_decoder`

## Requirements
- R1: After reset all four words are 0x0000. Neither serial port is mapped, both interrupt enables are low, the floppy enable is high, both window routes are external and the extra-RAM select is low.
- R2: The words sit at ports 0x2072, 0x2872, 0x5872 and 0xF872, each also claimed at port+1. A word write at a claimed port stores all 16 bits, and a word read there returns them. The word at 0x5872 drives no output.
- R3: A word read at any unclaimed port returns 0xFFFF.
- R4: A byte access at an even port addresses bits 7:0 of its word, and one at an odd port addresses bits 15:8. Byte write data is taken from io_wdata[7:0]. A byte read returns the addressed byte on io_rdata[7:0], with io_rdata[15:8] = 0xFF.
- R5: A byte write changes only the addressed byte. The other byte of the word keeps its value.
- R6: Serial port A is mapped when bit 4 of word 0x2072 is 0 and its bits 7:5 hold code 1, 2, 3 or 4, which select base 0x3F8, 0x2F8, 0x3E8 or 0x2E8. Any other code leaves it unmapped. uart_a_irq4 is high exactly while A is mapped. uart_a_cs is high while A is mapped and io_addr lies in the 8 ports from its base.
- R7: Serial port B follows the same rules, with bit 0 of word 0x2072 as its disable and bits 3:1 as its code. Its interrupt enable is uart_b_irq3.
- R8: flop_en is the inverse of bit 0 of word 0x2872. flop_cs is high while flop_en is high and io_addr lies in 0x3F0–0x3F7.
- R9: For mem_addr in 0xD0000–0xDFFFF, bit 0 of word 0xF872 routes reads internal (win_rd_int) and bit 1 routes writes internal (win_wr_int). Outside that window both outputs are low.
- R10: xram_cs is high while bit 2 of word 0xF872 is 1 and mem_addr lies in the window.
- R11: A write affects the outputs from the cycle after the strobe edge. In the strobe cycle itself the outputs still reflect the old contents. A write at an unclaimed port changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| io_wr | input | 1 | Write strobe |
| io_word | input | 1 | 1 = word access, 0 = byte access |
| io_rdata | output | 16 | Read data for io_addr / io_word |
| mem_addr | input | 20 | Memory address for window routing |
| uart_a_cs | output | 1 | Serial port A chip select |
| uart_a_irq4 | output | 1 | Serial port A owns IRQ 4 |
| uart_b_cs | output | 1 | Serial port B chip select |
| uart_b_irq3 | output | 1 | Serial port B owns IRQ 3 |
| flop_en | output | 1 | Floppy controller enabled at 0x3F0 |
| flop_cs | output | 1 | Floppy controller chip select |
| win_rd_int | output | 1 | Window read goes to internal memory |
| win_wr_int | output | 1 | Window write goes to internal memory |
| xram_cs | output | 1 | Extra RAM selected in the window |

## Verification
A configuration write and the decode that depends on it overlap in the same cycle. While the write strobe is high, io_addr is both the port being written and the address the serial and floppy selects decode. The window routing is also being evaluated against mem_addr from the still-unchanged word. The bench checks every output during the strobe cycle against the model's old contents, then again one cycle later against the updated contents. Random writes, with mixed widths and lanes, are interleaved with probes at window boundaries and at serial base offsets 0 to 9.

// File: rtl/sysctl_cfg_pkg.sv
package sysctl_cfg_pkg;

   localparam int NUM_REGS = 4;

   // word index assignment
   localparam int IDX_COM   = 0;
   localparam int IDX_FLOP  = 1;
   localparam int IDX_SPARE = 2;
   localparam int IDX_WIN   = 3;

   localparam logic [NUM_REGS-1:0][15:0] REG_PORTS =
      {16'hF872, 16'h5872, 16'h2872, 16'h2072};

   typedef struct packed {
      logic        valid;
      logic [15:0] base;
   } com_base_t;

   typedef enum logic [1:0] {
      ROUTE_ALL_EXT  = 2'd0,
      ROUTE_RD_INT   = 2'd1,
      ROUTE_WR_INT   = 2'd2,
      ROUTE_ALL_INT  = 2'd3
   } win_mode_e;

   function automatic com_base_t com_base_lookup(input logic [2:0] code);
      com_base_t r;
      r.valid = 1'b1;
      case (code)
         3'd1:    r.base = 16'h03F8;
         3'd2:    r.base = 16'h02F8;
         3'd3:    r.base = 16'h03E8;
         3'd4:    r.base = 16'h02E8;
         default: begin
            r.valid = 1'b0;
            r.base  = 16'h0000;
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cfg_regbank.sv
module cfg_regbank
   import sysctl_cfg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int NREG   = NUM_REGS
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic                         wr,
   input  logic                         word,
   output logic [DATA_W-1:0]            rdata,
   output logic [NREG-1:0][DATA_W-1:0]  regs
);

   localparam int BYTE_W = 8;
   localparam int NBYTES = DATA_W / BYTE_W;

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("cfg_regbank: DATA_W must be 16");
      end
      if (ADDR_W != 16) begin : g_bad_addr
         $error("cfg_regbank: ADDR_W must be 16");
      end
      if (NREG != NUM_REGS) begin : g_bad_count
         $error("cfg_regbank: NREG must match the port table");
      end
   endgenerate

   logic            lane_hi;
   logic [NREG-1:0] hit;

   assign lane_hi = addr[0];

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_reg
         assign hit[g] = (addr[ADDR_W-1:1] == REG_PORTS[g][ADDR_W-1:1]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[g] <= '0;
            end else if (wr && hit[g]) begin
               if (word) begin
                  regs[g] <= wdata;
               end else if (lane_hi) begin
                  regs[g][DATA_W-1:BYTE_W] <= wdata[BYTE_W-1:0];
               end else begin
                  regs[g][BYTE_W-1:0] <= wdata[BYTE_W-1:0];
               end
            end
         end
      end
   endgenerate

   logic [DATA_W-1:0] word_q;

   always_comb begin
      word_q = '1;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) word_q = regs[i];
      end
   end

   always_comb begin
      if (word) begin
         rdata = word_q;
      end else begin
         rdata = '1;
         rdata[BYTE_W-1:0] = lane_hi ? word_q[DATA_W-1:BYTE_W]
                                     : word_q[BYTE_W-1:0];
      end
   end

   logic unused_nbytes;
   assign unused_nbytes = (NBYTES == 0);

endmodule

// File: rtl/com_port_decode.sv
module com_port_decode
   import sysctl_cfg_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int SPAN    = 8,
   parameter int DIS_BIT = 4,
   parameter int SEL_LSB = 5
) (
   input  logic [15:0]       cfg,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              cs,
   output logic              mapped
);

   localparam int SPAN_LOG2 = $clog2(SPAN);

   generate
      if ((1 << SPAN_LOG2) != SPAN) begin : g_bad_span
         $error("com_port_decode: SPAN must be a power of two");
      end
      if (SEL_LSB + 3 > 16 || DIS_BIT > 15) begin : g_bad_field
         $error("com_port_decode: field outside configuration word");
      end
   endgenerate

   com_base_t sel;

   always_comb begin
      sel    = com_base_lookup(cfg[SEL_LSB +: 3]);
      mapped = !cfg[DIS_BIT] && sel.valid;
      cs     = mapped &&
               (io_addr[ADDR_W-1:SPAN_LOG2] == sel.base[ADDR_W-1:SPAN_LOG2]);
   end

endmodule

// File: rtl/umb_window_route.sv
module umb_window_route
   import sysctl_cfg_pkg::*;
#(
   parameter int          MEM_AW   = 20,
   parameter int          WIN_LOG2 = 16,
   parameter logic [19:0] WIN_BASE = 20'hD0000
) (
   input  logic [1:0]        mode,
   input  logic              xram_on,
   input  logic [MEM_AW-1:0] mem_addr,
   output logic              rd_int,
   output logic              wr_int,
   output logic              xram_cs
);

   generate
      if (WIN_LOG2 >= MEM_AW) begin : g_bad_win
         $error("umb_window_route: window wider than address space");
      end
      if (WIN_BASE[WIN_LOG2-1:0] != '0) begin : g_bad_align
         $error("umb_window_route: window base not aligned");
      end
   endgenerate

   logic      in_win;
   win_mode_e m;

   assign in_win = (mem_addr[MEM_AW-1:WIN_LOG2] == WIN_BASE[MEM_AW-1:WIN_LOG2]);
   assign m      = win_mode_e'(mode);

   always_comb begin
      rd_int = 1'b0;
      wr_int = 1'b0;
      if (in_win) begin
         case (m)
            ROUTE_ALL_EXT: begin rd_int = 1'b0; wr_int = 1'b0; end
            ROUTE_RD_INT:  begin rd_int = 1'b1; wr_int = 1'b0; end
            ROUTE_WR_INT:  begin rd_int = 1'b0; wr_int = 1'b1; end
            default:       begin rd_int = 1'b1; wr_int = 1'b1; end
         endcase
      end
      xram_cs = in_win && xram_on;
   end

endmodule

// File: rtl/sysctl_cfg_decoder.sv
module sysctl_cfg_decoder
   import sysctl_cfg_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 16,
   parameter int          MEM_AW    = 20,
   parameter int          COM_SPAN  = 8,
   parameter logic [15:0] FLOP_BASE = 16'h03F0,
   parameter int          FLOP_SPAN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       io_addr,
   input  logic [15:0]       io_wdata,
   input  logic              io_wr,
   input  logic              io_word,
   output logic [15:0]       io_rdata,
   input  logic [19:0]       mem_addr,
   output logic              uart_a_cs,
   output logic              uart_a_irq4,
   output logic              uart_b_cs,
   output logic              uart_b_irq3,
   output logic              flop_en,
   output logic              flop_cs,
   output logic              win_rd_int,
   output logic              win_wr_int,
   output logic              xram_cs
);

   localparam int NCOM      = 2;
   localparam int FLOP_LOG2 = $clog2(FLOP_SPAN);
   localparam int DIS_BITS [NCOM] = '{4, 0};
   localparam int SEL_LSBS [NCOM] = '{5, 1};

   generate
      if (ADDR_W != 16 || DATA_W != 16 || MEM_AW != 20) begin : g_bad_bus
         $error("sysctl_cfg_decoder: bus widths are fixed at 16/16/20");
      end
      if ((1 << FLOP_LOG2) != FLOP_SPAN) begin : g_bad_flop
         $error("sysctl_cfg_decoder: FLOP_SPAN must be a power of two");
      end
   endgenerate

   logic [NUM_REGS-1:0][15:0] regs;

   cfg_regbank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NREG   (NUM_REGS)
   ) i_regbank (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (io_addr),
      .wdata (io_wdata),
      .wr    (io_wr),
      .word  (io_word),
      .rdata (io_rdata),
      .regs  (regs)
   );

   logic [NCOM-1:0] com_cs;
   logic [NCOM-1:0] com_map;

   genvar c;
   generate
      for (c = 0; c < NCOM; c++) begin : g_com
         com_port_decode #(
            .ADDR_W  (ADDR_W),
            .SPAN    (COM_SPAN),
            .DIS_BIT (DIS_BITS[c]),
            .SEL_LSB (SEL_LSBS[c])
         ) i_com (
            .cfg     (regs[IDX_COM]),
            .io_addr (io_addr),
            .cs      (com_cs[c]),
            .mapped  (com_map[c])
         );
      end
   endgenerate

   assign uart_a_cs   = com_cs[0];
   assign uart_a_irq4 = com_map[0];
   assign uart_b_cs   = com_cs[1];
   assign uart_b_irq3 = com_map[1];

   assign flop_en = !regs[IDX_FLOP][0];
   assign flop_cs = flop_en &&
                    (io_addr[15:FLOP_LOG2] == FLOP_BASE[15:FLOP_LOG2]);

   umb_window_route #(
      .MEM_AW   (MEM_AW),
      .WIN_LOG2 (16),
      .WIN_BASE (20'hD0000)
   ) i_window (
      .mode     (regs[IDX_WIN][1:0]),
      .xram_on  (regs[IDX_WIN][2]),
      .mem_addr (mem_addr),
      .rd_int   (win_rd_int),
      .wr_int   (win_wr_int),
      .xram_cs  (xram_cs)
   );

   logic unused_spare;
   assign unused_spare = ^{regs[IDX_SPARE], regs[IDX_WIN][15:3],
                           regs[IDX_FLOP][15:1], regs[IDX_COM][15:8]};

endmodule

// File: rtl/sysctl_cfg_decoder_chk.sv
module sysctl_cfg_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] io_addr,
   input logic        io_wr,
   input logic        io_word,
   input logic [19:0] mem_addr,
   input logic        uart_a_cs,
   input logic        uart_a_irq4,
   input logic        uart_b_cs,
   input logic        uart_b_irq3,
   input logic        flop_en,
   input logic        flop_cs,
   input logic        win_rd_int,
   input logic        win_wr_int,
   input logic        xram_cs
);

   logic in_win;
   logic claimed;
   assign in_win  = (mem_addr[19:16] == 4'hD);
   assign claimed = (io_addr[15:1] == 15'h1039) || (io_addr[15:1] == 15'h1439) ||
                    (io_addr[15:1] == 15'h2C39) || (io_addr[15:1] == 15'h7C39);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |-> (flop_en && !uart_a_irq4 && !uart_b_irq3 && !xram_cs &&
                  !win_rd_int && !win_wr_int));

   // R6
   com_a_cs_mapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uart_a_cs |-> uart_a_irq4);

   // R7
   com_b_cs_mapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uart_b_cs |-> uart_b_irq3);

   // R8
   flop_cs_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flop_cs |-> flop_en);

   // R9
   route_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |-> (!win_rd_int && !win_wr_int));

   // R10
   xram_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xram_cs |-> in_win);

   // R5
   high_byte_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_word && io_addr == 16'h2073) |=>
         ($stable(uart_a_irq4) && $stable(uart_b_irq3)));

   // R11
   unclaimed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !claimed) |=>
         ($stable(uart_a_irq4) && $stable(uart_b_irq3) && $stable(flop_en)));

endmodule

bind sysctl_cfg_decoder sysctl_cfg_decoder_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_addr     (io_addr),
   .io_wr       (io_wr),
   .io_word     (io_word),
   .mem_addr    (mem_addr),
   .uart_a_cs   (uart_a_cs),
   .uart_a_irq4 (uart_a_irq4),
   .uart_b_cs   (uart_b_cs),
   .uart_b_irq3 (uart_b_irq3),
   .flop_en     (flop_en),
   .flop_cs     (flop_cs),
   .win_rd_int  (win_rd_int),
   .win_wr_int  (win_wr_int),
   .xram_cs     (xram_cs)
);

// File: tb/test_sysctl_cfg_decoder.sv
module test_sysctl_cfg_decoder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] io_addr;
   logic [15:0] io_wdata;
   logic        io_wr;
   logic        io_word;
   logic [15:0] io_rdata;
   logic [19:0] mem_addr;
   logic        uart_a_cs, uart_a_irq4, uart_b_cs, uart_b_irq3;
   logic        flop_en, flop_cs, win_rd_int, win_wr_int, xram_cs;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [15:0] m [4];
   logic [15:0] ports [4] = '{16'h2072, 16'h2872, 16'h5872, 16'hF872};
   logic [15:0] com_bases [4] = '{16'h03F8, 16'h02F8, 16'h03E8, 16'h02E8};

   always #2 clk = ~clk;

   sysctl_cfg_decoder i_sysctl_cfg_decoder (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_word(io_word), .io_rdata(io_rdata), .mem_addr(mem_addr),
      .uart_a_cs(uart_a_cs), .uart_a_irq4(uart_a_irq4),
      .uart_b_cs(uart_b_cs), .uart_b_irq3(uart_b_irq3),
      .flop_en(flop_en), .flop_cs(flop_cs),
      .win_rd_int(win_rd_int), .win_wr_int(win_wr_int), .xram_cs(xram_cs));

   function automatic int ridx(input logic [15:0] a);
      for (int i = 0; i < 4; i++) if (a[15:1] == ports[i][15:1]) return i;
      return -1;
   endfunction

   function automatic logic [16:0] exp_base(input logic [2:0] code);
      if (code >= 3'd1 && code <= 3'd4) return {1'b1, com_bases[code-1]};
      return 17'h0;
   endfunction

   task automatic chk(input string req, input string ctx,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h addr=%h mem=%h",
                  req, ctx, act, exp, io_addr, mem_addr);
      end
   endtask

   task automatic check_all(input string ctx);
      int          idx;
      logic [15:0] w, rd;
      logic [16:0] ba, bb;
      logic        ma, mb, fe, inw;
      idx = ridx(io_addr);
      w   = (idx < 0) ? 16'hFFFF : m[idx];
      rd  = io_word ? w : {8'hFF, io_addr[0] ? w[15:8] : w[7:0]};
      chk(idx < 0 ? "R3" : (io_word ? "R2" : "R4"), ctx, io_rdata, rd);
      ba = exp_base(m[0][7:5]);
      bb = exp_base(m[0][3:1]);
      ma = !m[0][4] && ba[16];
      mb = !m[0][0] && bb[16];
      chk("R6", {ctx, " irq4"}, {15'd0, uart_a_irq4}, {15'd0, ma});
      chk("R6", {ctx, " csA"},  {15'd0, uart_a_cs},
          {15'd0, ma && io_addr[15:3] == ba[15:3]});
      chk("R7", {ctx, " irq3"}, {15'd0, uart_b_irq3}, {15'd0, mb});
      chk("R7", {ctx, " csB"},  {15'd0, uart_b_cs},
          {15'd0, mb && io_addr[15:3] == bb[15:3]});
      fe = !m[1][0];
      chk("R8", {ctx, " fen"}, {15'd0, flop_en}, {15'd0, fe});
      chk("R8", {ctx, " fcs"}, {15'd0, flop_cs},
          {15'd0, fe && io_addr[15:3] == 13'h007E});
      inw = (mem_addr[19:16] == 4'hD);
      chk("R9",  {ctx, " rd"}, {15'd0, win_rd_int}, {15'd0, inw && m[3][0]});
      chk("R9",  {ctx, " wr"}, {15'd0, win_wr_int}, {15'd0, inw && m[3][1]});
      chk("R10", {ctx, " x"},  {15'd0, xram_cs},    {15'd0, inw && m[3][2]});
   endtask

   task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic word);
      int idx;
      @(negedge clk);
      io_addr = a; io_wdata = d; io_word = word; io_wr = 1'b1;
      #1 check_all("R11 strobe cycle");
      @(negedge clk);
      io_wr = 1'b0;
      idx = ridx(a);
      if (idx >= 0) begin
         if (word)      m[idx] = d;
         else if (a[0]) m[idx][15:8] = d[7:0];
         else           m[idx][7:0] = d[7:0];
      end
      #1 check_all("R11 after write");
   endtask

   task automatic probe(input logic [15:0] a, input logic word, input logic [19:0] ma);
      io_addr = a; io_word = word; mem_addr = ma;
      #1 check_all("probe");
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 4; i++) m[i] = 16'h0000;
      rst_n = 1'b0; io_addr = 16'h0000; io_wdata = 16'h0000;
      io_wr = 1'b0; io_word = 1'b1; mem_addr = 20'h00000;
      repeat (3) @(negedge clk);
      // R1: reset contents
      chk("R1", "reset fen", {15'd0, flop_en}, 16'd1);
      chk("R1", "reset irq", {14'd0, uart_a_irq4, uart_b_irq3}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      probe(16'h2072, 1'b1, 20'hD0000);
      probe(16'h03F8, 1'b1, 20'hDFFFF);

      // R6/R7 directed: A at 0x3F8, B at 0x2F8
      do_write(16'h2072, 16'h0024, 1'b1);
      probe(16'h03F8, 1'b1, 20'hCFFFF);
      probe(16'h03FF, 1'b1, 20'hE0000);
      probe(16'h0400, 1'b1, 20'hD8000);
      probe(16'h02FF, 1'b0, 20'hD8000);
      // R5: high byte write keeps low byte
      do_write(16'h2073, 16'h00A5, 1'b0);
      probe(16'h2072, 1'b1, 20'h00000);
      probe(16'h2073, 1'b0, 20'h00000);
      // R3 unclaimed
      probe(16'h2074, 1'b1, 20'h00000);
      probe(16'h2071, 1'b0, 20'h00000);
      do_write(16'h2074, 16'h0011, 1'b1);
      // R8
      do_write(16'h2872, 16'h0001, 1'b1);
      probe(16'h03F3, 1'b1, 20'h00000);
      do_write(16'h2872, 16'h0000, 1'b0);
      probe(16'h03F7, 1'b1, 20'h00000);
      // R2 spare storage
      do_write(16'h5872, 16'hBEEF, 1'b1);
      probe(16'h5873, 1'b0, 20'h00000);
      // R9/R10 all modes
      for (int k = 0; k < 8; k++) begin
         do_write(16'hF872, 16'(k), 1'b1);
         probe(16'h0000, 1'b1, 20'hD0000);
         probe(16'h0000, 1'b1, 20'hDFFFF);
         probe(16'h0000, 1'b1, 20'hCFFFF);
         probe(16'h0000, 1'b1, 20'hE0000);
      end

      // random mix
      for (int n = 0; n < 500; n++) begin
         int          kind;
         logic [15:0] a;
         kind = int'($urandom % 10);
         if (kind < 4)       a = ports[kind] | 16'($urandom % 2);
         else if (kind < 8)  a = ports[kind-4] + 16'(2 + $urandom % 4) - 16'd4;
         else                a = 16'($urandom);
         do_write(a, 16'($urandom), 1'($urandom));
         for (int p = 0; p < 2; p++) begin
            logic [19:0] ma;
            logic [15:0] pa;
            case ($urandom % 3)
               0: ma = {4'hD, 16'($urandom)};
               1: ma = {4'hC, 16'($urandom)};
               default: ma = 20'($urandom);
            endcase
            if ($urandom % 2) pa = com_bases[$urandom % 4] + 16'($urandom % 10);
            else if ($urandom % 2) pa = 16'h03F0 + 16'($urandom % 10);
            else pa = ports[$urandom % 4] + 16'($urandom % 3);
            probe(pa, 1'($urandom), ma);
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule